// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits beside a CPU core and decides which interrupt the core should service next. It takes 24 maskable request lines and one non-maskable line. The maskable sources are gated by per-source enable bits and by a global enable. The priority of each source comes from a 2-bit level that it shares with the other members of its group. The block presents the winner as a registered request. The request carries a vector index, a level and a non-maskable flag, and it stays steady until the core acknowledges it.

Acknowledge and return pulses from the core drive the nesting logic. An acknowledge records the granted rank on a small stack of active levels and drops the global enable. A return pops the stack and raises the global enable again. A handler can therefore be pre-empted only by a request of strictly higher rank, and only after software sets the global enable again. Each source can be set to latch a rising edge or to follow its line level. All inputs are synchronous to `clk`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source s belongs to group s mod 6, so group g holds sources g, g+6, g+12 and g+18. The level of group g is {pri_hi[g], pri_lo[g]}: level 3 is the highest and level 0 the lowest.
- R2: When eligible requests of different levels are pending, the request of the highest level is presented.
- R3: Among eligible requests of equal level, the lowest source number is presented.
- R4: Source s is eligible only when the global enable is 1 and its enable bit is 1. The enable bits form the flat vector {en_b3, en_b2, en_b1, en_b0[6:0]}, where bit s belongs to source s. A pulse on en0_wr loads the global enable from en_b0[7].
- R5: The global enable is cleared on the cycle after an accepted acknowledge. It is set on the cycle after reti. The acknowledge takes precedence over reti, and reti takes precedence over en0_wr.
- R6: The non-maskable request is captured on a rising edge of nmi_in. It ignores every enable and outranks all maskable sources. It is presented with req_nmi=1, req_vec=0 and req_lvl=3.
- R7: When irq_edge[s]=0, source s is pending only while irq_in[s] is high. When irq_edge[s]=1, a rising edge sets a pending flag, and that flag is cleared when the source is acknowledged.
- R8: An accepted acknowledge pushes a rank onto the active stack: the level plus 1 for a maskable source, and 5 for the non-maskable one. A request is presented only if its rank is strictly above the top of the stack, where an empty stack counts as 0. A reti pops one entry.
- R9: req_valid and its fields are registered. They stay unchanged while ack is low, and req_valid drops on the cycle after an ack arrives while req_valid is high.
- R10: After reset, req_valid is 0, the global enable is 0, the stack is empty and no edge flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 24 | Maskable request lines |
| irq_edge | input | 24 | Per-source capture mode, 1 = rising edge |
| nmi_in | input | 1 | Non-maskable request line |
| en_b0 | input | 8 | Enables for sources 0-6; bit 7 is the global enable write value |
| en_b1 | input | 8 | Enables for sources 7-14 |
| en_b2 | input | 8 | Enables for sources 15-22 |
| en_b3 | input | 8 | Bit 0 enables source 23 |
| en0_wr | input | 1 | Loads the global enable from en_b0[7] |
| pri_lo | input | 6 | Low level bit of each group |
| pri_hi | input | 6 | High level bit of each group |
| ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Core returns from a handler |
| req_valid | output | 1 | A request is presented |
| req_nmi | output | 1 | Presented request is non-maskable |
| req_vec | output | 5 | Presented source index |
| req_lvl | output | 2 | Presented level |

## Verification
The bench aims at level ties inside and across groups. Picking the highest index there, or using the source number instead of the group to find the level, would change the vector that is presented. It also aims at nesting under an equal rank: a design that compares against the stack with greater-or-equal would grant a same-level source during its own handler. Other targets are a level-mode pulse that drops while the source is masked, which would be granted by a design that latches it, and an edge flag that must clear on acknowledge, which would otherwise be served twice. A non-maskable handler must block a level-3 source, and a held request must not be replaced by a later winner before the acknowledge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int DEF_NUM_SRC = 24;
  localparam int DEF_NUM_GRP = 6;
  localparam int DEF_LVL_W   = 2;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] irq_edge,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic               nmi_in,
  input  logic               nmi_clr,
  output logic [NUM_SRC-1:0] pend,
  output logic               nmi_pend
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] flag_q;
  logic               nmi_prev_q;
  logic               nmi_flag_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[s] <= 1'b0;
        flag_q[s] <= 1'b0;
      end else begin
        prev_q[s] <= irq_in[s];
        if (irq_edge[s] && irq_in[s] && !prev_q[s])
          flag_q[s] <= 1'b1;
        else if (src_clr[s] || !irq_edge[s])
          flag_q[s] <= 1'b0;
      end
    end
    assign pend[s] = irq_edge[s] ? flag_q[s] : irq_in[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev_q <= 1'b0;
      nmi_flag_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_in;
      if (nmi_in && !nmi_prev_q) nmi_flag_q <= 1'b1;
      else if (nmi_clr)          nmi_flag_q <= 1'b0;
    end
  end
  assign nmi_pend = nmi_flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 24,
  parameter int NUM_GRP = 6,
  parameter int LVL_W   = 2,
  parameter int VEC_W   = 5,
  parameter int RANK_W  = 3
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               gen,
  input  logic [NUM_GRP-1:0] pri_lo,
  input  logic [NUM_GRP-1:0] pri_hi,
  input  logic [RANK_W-1:0]  top_rank,
  input  logic               nmi_pend,
  output logic               win_valid,
  output logic               win_nmi,
  output logic [VEC_W-1:0]   win_vec,
  output logic [LVL_W-1:0]   win_lvl
);
  localparam int NUM_LVL = 1 << LVL_W;
  localparam logic [RANK_W-1:0] RANK_NMI = RANK_W'(NUM_LVL + 1);

  logic [LVL_W-1:0]   src_lvl [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
    localparam int GRP = s % NUM_GRP;
    if (LVL_W == 2) begin : g_two
      assign src_lvl[s] = {pri_hi[GRP], pri_lo[GRP]};
    end else begin : g_one
      assign src_lvl[s] = LVL_W'(pri_lo[GRP]);
    end
    assign elig[s] = pend[s] && src_en[s] && gen &&
                     ((RANK_W'(src_lvl[s]) + RANK_W'(1)) > top_rank);
  end

  logic             found;
  logic             hit;
  logic [VEC_W-1:0] cand;
  logic [VEC_W-1:0] m_vec;
  logic [LVL_W-1:0] m_lvl;

  always_comb begin
    found = 1'b0;
    m_vec = '0;
    m_lvl = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      hit  = 1'b0;
      cand = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
        if (elig[s] && src_lvl[s] == LVL_W'(l)) begin
          hit  = 1'b1;
          cand = VEC_W'(s);
        end
      end
      if (hit && !found) begin
        found = 1'b1;
        m_vec = cand;
        m_lvl = LVL_W'(l);
      end
    end
  end

  logic nmi_ok;
  assign nmi_ok    = nmi_pend && (top_rank < RANK_NMI);
  assign win_valid = nmi_ok || found;
  assign win_nmi   = nmi_ok;
  assign win_vec   = nmi_ok ? '0 : m_vec;
  assign win_lvl   = nmi_ok ? '1 : m_lvl;
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int DEPTH  = 5,
  parameter int RANK_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [RANK_W-1:0] push_rank,
  input  logic              pop,
  output logic [RANK_W-1:0] top_rank,
  output logic [CNT_W-1:0]  cnt
);
  logic [RANK_W-1:0] stk_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && cnt_q == CNT_W'(i)) stk_q[i] <= push_rank;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                     cnt_q <= '0;
    else if (push && cnt_q < CNT_W'(DEPTH))      cnt_q <= cnt_q + 1'b1;
    else if (!push && pop && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    top_rank = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_rank = stk_q[i];
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int NUM_GRP = DEF_NUM_GRP,
  parameter int LVL_W   = DEF_LVL_W,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] irq_edge,
  input  logic               nmi_in,
  input  logic [7:0]         en_b0,
  input  logic [7:0]         en_b1,
  input  logic [7:0]         en_b2,
  input  logic [7:0]         en_b3,
  input  logic               en0_wr,
  input  logic [NUM_GRP-1:0] pri_lo,
  input  logic [NUM_GRP-1:0] pri_hi,
  input  logic               ack,
  input  logic               reti,
  output logic               req_valid,
  output logic               req_nmi,
  output logic [VEC_W-1:0]   req_vec,
  output logic [LVL_W-1:0]   req_lvl
);
  localparam int STK_DEPTH = (1 << LVL_W) + 1;
  localparam int RANK_W    = $clog2(STK_DEPTH + 1);
  localparam int CNT_W     = $clog2(STK_DEPTH + 1);
  localparam int EN_W      = 31;
  localparam logic [RANK_W-1:0] RANK_NMI = RANK_W'(STK_DEPTH);

  logic [EN_W-1:0]    en_flat;
  logic [NUM_SRC-1:0] src_en;
  assign en_flat = {en_b3, en_b2, en_b1, en_b0[6:0]};
  assign src_en  = en_flat[NUM_SRC-1:0];
  if (NUM_SRC < EN_W) begin : g_spare
    logic unused_en;
    assign unused_en = ^en_flat[EN_W-1:NUM_SRC];
  end

  logic               ga_q;
  logic               take;
  logic [NUM_SRC-1:0] src_clr;
  logic               nmi_clr;
  logic [NUM_SRC-1:0] pend;
  logic               nmi_pend;
  logic [RANK_W-1:0]  top_rank;
  logic [RANK_W-1:0]  push_rank;
  logic [CNT_W-1:0]   stk_cnt;
  logic               win_valid;
  logic               win_nmi;
  logic [VEC_W-1:0]   win_vec;
  logic [LVL_W-1:0]   win_lvl;

  assign take    = ack && req_valid;
  assign nmi_clr = take && req_nmi;
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
    assign src_clr[s] = take && !req_nmi && (req_vec == VEC_W'(s));
  end
  assign push_rank = req_nmi ? RANK_NMI : (RANK_W'(req_lvl) + RANK_W'(1));

  irq_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_edge(irq_edge),
    .src_clr(src_clr), .nmi_in(nmi_in), .nmi_clr(nmi_clr),
    .pend(pend), .nmi_pend(nmi_pend)
  );

  irq_level_stack #(.DEPTH(STK_DEPTH), .RANK_W(RANK_W), .CNT_W(CNT_W)) u_stack (
    .clk(clk), .rst(rst), .push(take), .push_rank(push_rank), .pop(reti),
    .top_rank(top_rank), .cnt(stk_cnt)
  );

  irq_arbiter #(
    .NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .LVL_W(LVL_W),
    .VEC_W(VEC_W), .RANK_W(RANK_W)
  ) u_arb (
    .pend(pend), .src_en(src_en), .gen(ga_q), .pri_lo(pri_lo), .pri_hi(pri_hi),
    .top_rank(top_rank), .nmi_pend(nmi_pend),
    .win_valid(win_valid), .win_nmi(win_nmi), .win_vec(win_vec), .win_lvl(win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst)         ga_q <= 1'b0;
    else if (take)   ga_q <= 1'b0;
    else if (reti)   ga_q <= 1'b1;
    else if (en0_wr) ga_q <= en_b0[7];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_nmi   <= 1'b0;
      req_vec   <= '0;
      req_lvl   <= '0;
    end else if (take) begin
      req_valid <= 1'b0;
    end else if (!req_valid) begin
      req_valid <= win_valid;
      req_nmi   <= win_nmi;
      req_vec   <= win_vec;
      req_lvl   <= win_lvl;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int NUM_SRC   = 24,
  parameter int VEC_W     = 5,
  parameter int LVL_W     = 2,
  parameter int CNT_W     = 3,
  parameter int STK_DEPTH = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic             reti,
  input logic             req_valid,
  input logic             req_nmi,
  input logic [VEC_W-1:0] req_vec,
  input logic [LVL_W-1:0] req_lvl,
  input logic             ga_q,
  input logic [CNT_W-1:0] stk_cnt
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !ack |=> req_valid && $stable(req_vec) && $stable(req_nmi) && $stable(req_lvl)); // R9
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    req_valid && ack |=> !req_valid); // R9
  AST_GA_CLEAR: assert property (@(posedge clk) disable iff (rst)
    req_valid && ack |=> !ga_q); // R5
  AST_GA_SET: assert property (@(posedge clk) disable iff (rst)
    reti && !(req_valid && ack) |=> ga_q); // R5
  AST_MASK_GA: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) && !req_nmi |-> $past(ga_q)); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_nmi |-> req_vec < VEC_W'(NUM_SRC)); // R1
  AST_NMI_FIELDS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_nmi |-> req_vec == '0 && req_lvl == '1); // R6
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    stk_cnt <= CNT_W'(STK_DEPTH)); // R8
  AST_NEST_PUSH: assert property (@(posedge clk) disable iff (rst)
    req_valid && ack |=> stk_cnt == $past(stk_cnt) + 1'b1); // R8
endmodule

bind irq_prio_ctrl irq_prio_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .LVL_W(LVL_W),
  .CNT_W(CNT_W), .STK_DEPTH(STK_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .reti(reti), .req_valid(req_valid),
  .req_nmi(req_nmi), .req_vec(req_vec), .req_lvl(req_lvl),
  .ga_q(ga_q), .stk_cnt(stk_cnt)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int N = 24;
  localparam int G = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] irq_in = '0, irq_edge = '0;
  logic         nmi_in = 1'b0;
  logic [7:0]   en_b0 = '0, en_b1 = '0, en_b2 = '0, en_b3 = '0;
  logic         en0_wr = 1'b0;
  logic [G-1:0] pri_lo = '0, pri_hi = '0;
  logic         ack = 1'b0, reti = 1'b0;
  logic         req_valid, req_nmi;
  logic [4:0]   req_vec;
  logic [1:0]   req_lvl;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_edge(irq_edge), .nmi_in(nmi_in),
    .en_b0(en_b0), .en_b1(en_b1), .en_b2(en_b2), .en_b3(en_b3), .en0_wr(en0_wr),
    .pri_lo(pri_lo), .pri_hi(pri_hi), .ack(ack), .reti(reti),
    .req_valid(req_valid), .req_nmi(req_nmi), .req_vec(req_vec), .req_lvl(req_lvl)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int mcnt = 0;
  int mstk [8];
  bit mga = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int mtop();
    return (mcnt == 0) ? 0 : mstk[mcnt-1];
  endfunction

  task automatic write_ga(bit v);
    en_b0[7] = v; en0_wr = 1'b1; step(1); en0_wr = 1'b0; mga = v;
  endtask

  task automatic do_ack(int rank);
    ack = 1'b1; step(1); ack = 1'b0;
    mstk[mcnt] = rank; mcnt++; mga = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; step(1); reti = 1'b0;
    if (mcnt > 0) mcnt--;
    mga = 1'b1;
  endtask

  // Expected winner among level-mode maskable sources
  function automatic bit exp_win(output int vec, output int lvl);
    logic [30:0] ef;
    int best, bl, l;
    ef = {en_b3, en_b2, en_b1, en_b0[6:0]};
    best = -1; bl = -1;
    for (int s = 0; s < N; s++) begin
      if (irq_in[s] && ef[s] && mga) begin
        l = {pri_hi[s % G], pri_lo[s % G]};
        if (l + 1 > mtop() && l > bl) begin bl = l; best = s; end
      end
    end
    vec = best; lvl = bl;
    return best >= 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ev, el;
    bit ew;
    void'($urandom(32'd4242));
    step(3); rst = 1'b0; step(1);
    chk("R10 reset req_valid", req_valid, 0);
    irq_in = '1; en_b0 = 8'h7F; en_b1 = '1; en_b2 = '1; en_b3 = '1;
    step(3);
    chk("R10 global enable resets to 0", req_valid, 0);
    irq_in = '0;

    // R4 individual enable of source 9 (en_b1 bit 2)
    en_b1 = 8'hFB; irq_in[9] = 1'b1; write_ga(1); step(3);
    chk("R4 masked source", req_valid, 0);
    en_b1 = 8'hFF; step(3);
    chk("R4 enabled source valid", req_valid, 1);
    chk("R4 enabled source vec", req_vec, 9);
    do_ack(1); irq_in = '0; do_reti(); step(2);

    // R3 tie within a group, R1 grouping
    pri_lo = '0; pri_hi = '0; irq_in[6] = 1'b1; irq_in[12] = 1'b1; step(3);
    chk("R3 tie lowest index", req_vec, 6);
    do_ack(1); irq_in = '0; do_reti(); step(2);

    // R2 higher level wins: group 5 level 2 against group 0 level 1
    pri_lo = 6'b000001; pri_hi = 6'b100000; irq_in[0] = 1'b1; irq_in[5] = 1'b1; step(3);
    chk("R2 higher level vec", req_vec, 5);
    chk("R1 group level", req_lvl, 2);
    do_ack(3); irq_in = '0; do_reti(); step(2);

    // R6 non-maskable ignores global enable and outranks level 3
    write_ga(0); nmi_in = 1'b1; step(3);
    chk("R6 nmi valid", req_valid, 1);
    chk("R6 nmi flag", req_nmi, 1);
    chk("R6 nmi vec", req_vec, 0);
    do_ack(5); nmi_in = 1'b0;
    pri_lo = '1; pri_hi = '1; irq_in[0] = 1'b1; write_ga(1); step(3);
    chk("R6 nmi blocks level 3", req_valid, 0);
    do_reti(); step(3);
    chk("R8 pop lets level 3 in", req_valid, 1);
    chk("R6 maskable flag", req_nmi, 0);
    chk("R1 level 3", req_lvl, 3);
    do_ack(4); irq_in = '0; do_reti(); step(2);

    // R7 edge capture and clear on acknowledge
    irq_edge[4] = 1'b1; irq_in[4] = 1'b1; step(1); irq_in[4] = 1'b0; step(3);
    chk("R7 edge latched valid", req_valid, 1);
    chk("R7 edge latched vec", req_vec, 4);
    do_ack(4); step(1); do_reti(); step(3);
    chk("R7 edge flag cleared", req_valid, 0);
    irq_edge = '0; write_ga(0); irq_in[4] = 1'b1; step(2); irq_in[4] = 1'b0; step(1);
    write_ga(1); step(3);
    chk("R7 level pulse not kept", req_valid, 0);

    // R8 R9 nesting and hold
    pri_lo = 6'b000011; pri_hi = 6'b000010;
    irq_in[0] = 1'b1; step(3);
    chk("R8 first grant vec", req_vec, 0);
    chk("R8 first grant lvl", req_lvl, 1);
    irq_in[1] = 1'b1; step(2);
    chk("R9 held vector", req_vec, 0);
    do_ack(2); step(2);
    chk("R5 global enable cleared on ack", req_valid, 0);
    write_ga(1); step(3);
    chk("R8 preempt vec", req_vec, 1);
    chk("R8 preempt lvl", req_lvl, 3);
    do_ack(4); irq_in[1] = 1'b0; write_ga(1); step(3);
    chk("R8 lower blocked", req_valid, 0);
    do_reti(); step(3);
    chk("R8 equal rank blocked", req_valid, 0);
    do_reti(); step(3);
    chk("R5 R8 after return vec", req_vec, 0);
    chk("R5 R8 after return valid", req_valid, 1);
    do_ack(2); irq_in = '0; do_reti(); step(2);

    // Random level-mode patterns
    for (int it = 0; it < 200; it++) begin
      irq_in = N'($urandom); en_b0 = 8'($urandom); en_b1 = 8'($urandom);
      en_b2 = 8'($urandom); en_b3 = 8'($urandom);
      pri_lo = G'($urandom); pri_hi = G'($urandom);
      write_ga(1); step(3);
      ew = exp_win(ev, el);
      chk("R2 R3 R4 random valid", req_valid, int'(ew));
      if (ew && req_valid) begin
        chk("R2 R3 random vec", req_vec, ev);
        chk("R1 random lvl", req_lvl, el);
        do_ack(el + 1); step(2);
        chk("R5 random ga cleared", req_valid, 0);
        do_reti(); step(3);
        ew = exp_win(ev, el);
        chk("R5 R8 random re-request", req_vec, ev);
        irq_in = '0; do_ack(el + 1); step(1); do_reti(); step(2);
      end
      irq_in = '0; step(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule